// File: doc/BRIEF.md
# Edge-Detecting General-Purpose I/O Port

This block is a 28-pin general-purpose I/O port controlled through a small register bus. Each pin is an input or an output, chosen by its bit in a direction register. Output values are held in an output latch. Software changes the latch through two write-only strobe registers: one sets bits and the other clears them, so no read-modify-write is needed. A level register reads back the state of every pin. Output pins report the latch, and input pins report the synchronised external value.

Input pins pass through a two-stage synchroniser. Each pin has its own rising-edge enable and falling-edge enable. A detected edge sets a sticky bit in an edge status register, and software clears that bit by writing a 1 to it. The low eleven status bits each drive a dedicated interrupt line. The remaining seventeen bits are ORed onto one shared interrupt line. A function-select register is stored for software but does not change pin behaviour.

Register offsets are byte addresses, decoded on `addr[4:2]`:

| Offset | Register |
|---|---|
| 0x00 | level (read only) |
| 0x04 | direction |
| 0x08 | set strobe (write only) |
| 0x0C | clear strobe (write only) |
| 0x10 | rising-edge enable |
| 0x14 | falling-edge enable |
| 0x18 | edge status (write 1 to clear) |
| 0x1C | function select |

Reads are combinational from `addr`. A write takes effect at the clock edge where `wr_en` is high.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After reset, every register reads 0, `pin_out` is 0 and all interrupt outputs are 0.
- R2: Direction bit 1 makes a pin an output. `pin_out` equals the output latch ANDed with the direction register (offset 0x04).
- R3: Writing to offset 0x08 ORs the data into the output latch. Writing to offset 0x0C clears the latch bits that are written as 1. Both offsets read as 0.
- R4: Offset 0x00 returns the latch bit for output pins and the synchronised input for input pins. A change on `pin_in` becomes visible there two clock edges after it is sampled.
- R5: A 0-to-1 change of a synchronised input sets its status bit at the next edge. This happens only when the pin's rising enable (offset 0x10) is 1 and its direction bit is 0.
- R6: A 1-to-0 change sets the status bit under the same rules, using the falling enable at offset 0x14.
- R7: Writing 1s to offset 0x18 clears those status bits, and 0 bits leave status unchanged. If an edge on a bit lands in the same cycle as a clear of that bit, the bit stays set.
- R8: `irq_pin[i]` follows status bit i for i = 0 to 10. `irq_shared` is the OR of status bits 11 to 27.
- R9: The function-select register (offset 0x1C) reads back what was written and has no effect on `pin_out`, the level readback or edge detection.
- R10: The direction, both enable and function-select registers are read/write. Bits 28 to 31 are dropped on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| pin_in | input | 28 | External pin levels (asynchronous) |
| pin_out | output | 28 | Driven pin values, masked by direction |
| irq_pin | output | 11 | Dedicated interrupts, pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt, pins 11 to 27 |

## Verification
Edge detection and a software clear can act on the same status bit in the same cycle. The bench provokes this by dropping one input pin and then timing a write-1-to-clear so that it lands exactly on the edge where the synchronised falling edge is registered. The expected result is that the bit survives. A second clear with no edge pending must then remove it. A cycle-level behavioural model judges the same race during a long stretch of random writes and random pin changes, comparing read data, pin outputs and interrupts on every clock.

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl #(
  parameter int NPINS = 28,
  parameter int NDED  = 11,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NDED-1:0]  irq_pin,
  output logic             irq_shared
);
  localparam logic [2:0] SEL_LVL = 3'd0, SEL_DIR = 3'd1, SEL_SET = 3'd2, SEL_CLR = 3'd3,
                         SEL_REN = 3'd4, SEL_FEN = 3'd5, SEL_STS = 3'd6, SEL_FSEL = 3'd7;

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] dir, latch, ren, fen, status, fsel;
  logic [NPINS-1:0] rd_n;

  wire [2:0]       sel  = addr[4:2];
  wire [NPINS-1:0] wdat = wr_data[NPINS-1:0];
  wire unused_bits = &{1'b0, addr[1:0], wr_data[DW-1:NPINS]};

  wire [NPINS-1:0] rise = sync2 & ~prev & ~dir & ren;
  wire [NPINS-1:0] fall = ~sync2 & prev & ~dir & fen;
  wire [NPINS-1:0] clr_mask = (wr_en && sel == SEL_STS) ? wdat : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      dir    <= '0;
      latch  <= '0;
      ren    <= '0;
      fen    <= '0;
      status <= '0;
      fsel   <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      prev   <= sync2;
      status <= (status & ~clr_mask) | rise | fall;
      if (wr_en) begin
        case (sel)
          SEL_DIR:  dir   <= wdat;
          SEL_SET:  latch <= latch | wdat;
          SEL_CLR:  latch <= latch & ~wdat;
          SEL_REN:  ren   <= wdat;
          SEL_FEN:  fen   <= wdat;
          SEL_FSEL: fsel  <= wdat;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_LVL:  rd_n = (latch & dir) | (sync2 & ~dir);
      SEL_DIR:  rd_n = dir;
      SEL_REN:  rd_n = ren;
      SEL_FEN:  rd_n = fen;
      SEL_STS:  rd_n = status;
      SEL_FSEL: rd_n = fsel;
      default:  rd_n = '0;
    endcase
    rd_data = '0;
    rd_data[NPINS-1:0] = rd_n;
  end

  assign pin_out    = latch & dir;
  assign irq_pin    = status[NDED-1:0];
  assign irq_shared = |status[NPINS-1:NDED];
endmodule

// File: rtl/gpio_edge_ctl_chk.sv
module gpio_edge_ctl_chk #(
  parameter int NPINS = 28,
  parameter int NDED  = 11,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wr_data,
  input logic [DW-1:0]    rd_data,
  input logic [NPINS-1:0] pin_out,
  input logic             irq_shared,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] latch,
  input logic [NPINS-1:0] status
);
  wire [NPINS-1:0] wd = wr_data[NPINS-1:0];
  wire [NPINS-1:0] chk_clr = (wr_en && addr[4:2] == 3'd6) ? wd : '0;
  wire unused_chk = &{1'b0, addr[1:0], wr_data[DW-1:NPINS]};

  p_out_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~dir) == '0);

  p_strobe_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[4:2] == 3'd2 || addr[4:2] == 3'd3) |-> rd_data == '0);

  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[4:2] == 3'd2) |=> (latch & $past(wd)) == $past(wd));

  p_edge_inputs_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & $past(dir)) == '0);

  p_sticky_until_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~$past(chk_clr)) & ~status) == '0);

  p_shared_from_new_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_shared) |-> $past(status[NPINS-1:NDED]) == '0);
endmodule

bind gpio_edge_ctl gpio_edge_ctl_chk #(.NPINS(NPINS), .NDED(NDED), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .pin_out(pin_out), .irq_shared(irq_shared),
  .dir(dir), .latch(latch), .status(status)
);

// File: tb/tb_gpio_edge_ctl.sv
`timescale 1ns/100ps
module tb_gpio_edge_ctl;
  localparam int N = 28;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [N-1:0] pin_in = '0, pin_out;
  logic [10:0] irq_pin;
  logic irq_shared;
  int checks = 0, failures = 0;
  bit done = 0;

  gpio_edge_ctl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .irq_pin(irq_pin), .irq_shared(irq_shared));

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [N-1:0] m_dir, m_lat, m_ren, m_fen, m_st, m_fs;
  logic [N-1:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_lat = 0; m_ren = 0; m_fen = 0; m_st = 0; m_fs = 0;
      hist.delete();
      repeat (3) hist.push_back('0);
    end else begin
      logic [N-1:0] now_v, old_v, w, clr;
      now_v = hist[hist.size()-2];
      old_v = hist[hist.size()-3];
      w = wr_data[N-1:0];
      clr = 0;
      if (wr_en && addr[4:2] == 6) clr = w;
      for (int b = 0; b < N; b++) begin
        if (!m_dir[b] && ((m_ren[b] && now_v[b] && !old_v[b]) || (m_fen[b] && !now_v[b] && old_v[b])))
          m_st[b] = 1'b1;
        else if (clr[b])
          m_st[b] = 1'b0;
      end
      if (wr_en) begin
        case (addr[4:2])
          1: m_dir = w;
          2: m_lat = m_lat | w;
          3: m_lat = m_lat & ~w;
          4: m_ren = w;
          5: m_fen = w;
          7: m_fs = w;
          default: ;
        endcase
      end
      hist.push_back(pin_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] lvl, er;
      string tag;
      lvl = (m_lat & m_dir) | (hist[hist.size()-2] & ~m_dir);
      case (addr[4:2])
        0: begin er = lvl;   tag = "R4 level"; end
        1: begin er = m_dir; tag = "R10 direction"; end
        2, 3: begin er = 0;  tag = "R3 strobe read"; end
        4: begin er = m_ren; tag = "R10 rise enable"; end
        5: begin er = m_fen; tag = "R10 fall enable"; end
        6: begin er = m_st;  tag = "R7 status"; end
        default: begin er = m_fs; tag = "R9 function select"; end
      endcase
      chk(tag, rd_data, {4'b0, er});
      chk("R2 pin_out", {4'b0, pin_out}, {4'b0, m_lat & m_dir});
      chk("R8 irq", {20'b0, irq_shared, irq_pin}, {20'b0, |m_st[N-1:11], m_st[10:0]});
    end
  end

  task automatic tick(); @(negedge clk); #1; wr_en = 0; endtask
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); #1; wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); #1; wr_en = 0;
  endtask
  task automatic rdchk(logic [4:0] a, logic [31:0] exp, string tag);
    addr = a; #0.5; chk(tag, rd_data, exp);
  endtask
  task automatic setpins(logic [N-1:0] v, int waitc);
    @(negedge clk); #1; pin_in = v;
    repeat (waitc) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rdchk(5'(a * 4), 0, "R1 reset read");
    chk("R1 reset pin_out", {4'b0, pin_out}, 0);
    chk("R1 reset irq", {20'b0, irq_shared, irq_pin}, 0);

    // R2 / R3 output path
    wr(5'h04, 32'hF0F000FF);
    rdchk(5'h04, 32'h00F000FF, "R10 direction masked");
    wr(5'h08, 32'hFFFFFFFF);
    chk("R2 pin_out after set", {4'b0, pin_out}, 32'h00F000FF);
    wr(5'h0C, 32'h0000000F);
    chk("R3 pin_out after clear", {4'b0, pin_out}, 32'h00F000F0);
    rdchk(5'h08, 0, "R3 set reads zero");
    rdchk(5'h0C, 0, "R3 clear reads zero");

    // R4 level readback
    setpins(28'hAAAAAAA, 3);
    rdchk(5'h00, 32'h0AFAAAF0, "R4 mixed level");

    // R9 function select has no effect
    wr(5'h1C, 32'hFFFFFFFF);
    rdchk(5'h1C, 32'h0FFFFFFF, "R9 function select readback");
    chk("R9 pin_out unchanged", {4'b0, pin_out}, 32'h00F000F0);
    rdchk(5'h00, 32'h0AFAAAF0, "R9 level unchanged");

    // R5 rising edges, input pins only
    wr(5'h04, 32'h1);
    setpins(0, 4);
    wr(5'h10, 32'hFFFFFFFF);
    wr(5'h18, 32'hFFFFFFFF);
    setpins(28'h0000801, 4);
    rdchk(5'h18, 32'h800, "R5 rise on input only");
    chk("R8 shared irq", {20'b0, irq_shared, irq_pin}, 32'h800);

    // R6 falling edges
    wr(5'h14, 32'hFFFFFFFF);
    wr(5'h18, 32'h800);
    rdchk(5'h18, 0, "R7 clear");
    setpins(0, 4);
    rdchk(5'h18, 32'h800, "R6 fall on input only");

    // R8 dedicated lines
    wr(5'h04, 0);
    wr(5'h18, 32'hFFFFFFFF);
    setpins(28'h00007FF, 4);
    chk("R8 dedicated irq", {20'b0, irq_shared, irq_pin}, 32'h7FF);

    // R7 edge and clear in the same cycle: edge wins
    @(negedge clk); #1; pin_in = 28'h00007F7;
    @(negedge clk); #1;
    @(negedge clk); #1; wr_en = 1; addr = 5'h18; wr_data = 32'h8;
    @(negedge clk); #1; wr_en = 0;
    rdchk(5'h18, 32'h7FF, "R7 edge beats clear");
    wr(5'h18, 32'h8);
    rdchk(5'h18, 32'h7F7, "R7 clear without edge");

    // random stress against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      wr_en = ($urandom % 3) == 0;
      addr = 5'($urandom % 32);
      wr_data = $urandom;
      if ($urandom % 4 == 0) pin_in = N'($urandom);
    end
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule